// File: doc/BRIEF.md
# Configurable Stream Register Slice

This block sits between an upstream producer and a downstream consumer that both use a valid/ready handshake. A transfer happens on a clock edge where valid and ready are both high. The slice adds registers to cut long timing paths. The `MODE` parameter picks which paths are cut. Each mode has its own latency, flop cost and throughput.

- **Forward (0):** registers valid and payload.
- **Backward (1):** registers the ready path with a one-word skid buffer.
- **Half (2):** registers every path, but can move at most one word every other cycle.
- **Full (3):** a backward stage followed by a forward stage, so no combinational path joins the two sides.

A drop input sits in front of the stage. While it is high, the current upstream word is accepted and discarded, and nothing is forwarded for it. A typical use is filtering out words that match a condition, such as all-zero pixels. The payload is a flat bit vector. Its value means nothing while its valid is low.

Top module: `strm_reg_slice`

## Requirements
- R1: Reset is synchronous and active high, and it clears every valid flag. While reset is held with `inValid` low, `outValid` is low in every mode. In modes 0, 2 and 3, `outValid` is low on the cycle after a reset edge.
- R2: In every mode and under any valid, ready and drop pattern, each non-dropped word accepted upstream leaves downstream exactly once. Words leave in the order they were accepted.
- R3: When `outValid` is high and `outReady` is low, the next cycle still shows `outValid` high with an unchanged `outData`.
- R4: MODE=0 (forward) has one cycle of latency. A word accepted into an empty slice is not visible in the same cycle. With `inValid` and `outReady` held high from an empty state, 39 words leave in 40 cycles.
- R5: MODE=1 (backward) has zero latency. With the skid register empty, `outValid`/`outData` follow `inValid`/`inData` in the same cycle. A word accepted while downstream is stalled is kept, and `inReady` is low on the next cycle until that word drains. Under continuous flow, 40 words leave in 40 cycles.
- R6: MODE=2 (half) has `outValid` low on the cycle after every output transfer. `inReady` is low while a word is held. Under continuous flow, 20 words leave in 40 cycles.
- R7: MODE=3 (full) has one cycle of latency and full throughput: 39 words leave in 40 cycles from an empty state under continuous flow.
- R8: While `dropEn` is high, `inReady` is high. The upstream word present is consumed, and it never appears at the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dropEn | input | 1 | Discard the current upstream word |
| inValid | input | 1 | Upstream word present |
| inReady | output | 1 | Slice accepts the upstream word |
| inData | input | WIDTH | Upstream payload |
| outValid | output | 1 | Downstream word present |
| outReady | input | 1 | Downstream accepts the word |
| outData | output | WIDTH | Downstream payload |

## Verification
The bench drives all four modes from shared stimulus and keeps a separate expected-order queue for each. Random stall and drop patterns would expose a backward stage that overwrites its skid word: that shows up as a lost word. The same patterns would expose a forward stage that reloads under a stall: that shows up as a repeated word. Directed sequences measure same-cycle visibility and throughput in each mode. A half stage that reloaded while full would exceed 20 words in 40 cycles. A full stage built the wrong way round would lose a cycle or a word. A drop window followed by a silent output confirms that discarded words are never forwarded.

// File: rtl/strm_slice_pkg.sv
package strm_slice_pkg;
  localparam int SLICE_FWD  = 0;
  localparam int SLICE_BWD  = 1;
  localparam int SLICE_HALF = 2;
  localparam int SLICE_FULL = 3;

  // strobes from stage control to stage datapath
  typedef struct packed {
    logic loadMain;  // capture upstream word in main register
    logic loadSkid;  // capture upstream word in skid register
    logic selSkid;   // present skid register downstream
  } slice_strobe_t;
endpackage

// File: rtl/slice_ctrl.sv
module slice_ctrl
  import strm_slice_pkg::*;
#(
  parameter int KIND = SLICE_FWD
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upValid,
  output logic          upReady,
  output logic          downValid,
  input  logic          downReady,
  output slice_strobe_t strobe
);
  if (KIND == SLICE_BWD) begin : g_bwd
    logic skidFull;
    assign upReady   = !skidFull;
    assign downValid = upValid || skidFull;
    always_comb begin
      strobe          = '0;
      strobe.loadSkid = upValid && !skidFull && !downReady;
      strobe.selSkid  = skidFull;
    end
    always_ff @(posedge clk) begin
      if (rst)                        skidFull <= 1'b0;
      else if (skidFull && downReady) skidFull <= 1'b0;
      else if (strobe.loadSkid)       skidFull <= 1'b1;
    end
  end else if (KIND == SLICE_HALF) begin : g_half
    logic mainFull;
    assign upReady   = !mainFull;
    assign downValid = mainFull;
    always_comb begin
      strobe          = '0;
      strobe.loadMain = upValid && !mainFull;
    end
    always_ff @(posedge clk) begin
      if (rst)                        mainFull <= 1'b0;
      else if (mainFull && downReady) mainFull <= 1'b0;
      else if (strobe.loadMain)       mainFull <= 1'b1;
    end
  end else begin : g_fwd
    logic mainFull;
    assign upReady   = !mainFull || downReady;
    assign downValid = mainFull;
    always_comb begin
      strobe          = '0;
      strobe.loadMain = upValid && upReady;
    end
    always_ff @(posedge clk) begin
      if (rst)          mainFull <= 1'b0;
      else if (upReady) mainFull <= upValid;
    end
  end
endmodule

// File: rtl/slice_data.sv
module slice_data
  import strm_slice_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int KIND  = SLICE_FWD
) (
  input  logic             clk,
  input  slice_strobe_t    strobe,
  input  logic [WIDTH-1:0] upData,
  output logic [WIDTH-1:0] downData
);
  logic unusedStrobe;
  assign unusedStrobe = ^strobe;

  if (KIND == SLICE_BWD) begin : g_skid
    logic [WIDTH-1:0] skidReg;
    always_ff @(posedge clk) begin
      if (strobe.loadSkid) skidReg <= upData;
    end
    assign downData = strobe.selSkid ? skidReg : upData;
  end else begin : g_main
    logic [WIDTH-1:0] mainReg;
    always_ff @(posedge clk) begin
      if (strobe.loadMain) mainReg <= upData;
    end
    assign downData = mainReg;
  end
endmodule

// File: rtl/strm_reg_slice.sv
module strm_reg_slice
  import strm_slice_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int MODE  = SLICE_FWD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dropEn,
  input  logic             inValid,
  output logic             inReady,
  input  logic [WIDTH-1:0] inData,
  output logic             outValid,
  input  logic             outReady,
  output logic [WIDTH-1:0] outData
);
  localparam int NSTAGE = (MODE == SLICE_FULL) ? 2 : 1;

  // per-stage stream links: index s feeds stage s, index NSTAGE is the output
  logic             lnkValid [NSTAGE+1];
  logic             lnkReady [NSTAGE+1];
  logic [WIDTH-1:0] lnkData  [NSTAGE+1];

  // drop filter: consume without forwarding
  assign lnkValid[0] = inValid && !dropEn;
  assign lnkData[0]  = inData;
  assign inReady     = lnkReady[0] || dropEn;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    localparam int KIND = (MODE == SLICE_FULL) ? ((s == 0) ? SLICE_BWD : SLICE_FWD) : MODE;
    slice_strobe_t stb;

    slice_ctrl #(.KIND(KIND)) ctrl_i (
      .clk       (clk),
      .rst       (rst),
      .upValid   (lnkValid[s]),
      .upReady   (lnkReady[s]),
      .downValid (lnkValid[s+1]),
      .downReady (lnkReady[s+1]),
      .strobe    (stb)
    );

    slice_data #(.WIDTH(WIDTH), .KIND(KIND)) data_i (
      .clk      (clk),
      .strobe   (stb),
      .upData   (lnkData[s]),
      .downData (lnkData[s+1])
    );
  end

  assign outValid         = lnkValid[NSTAGE];
  assign outData          = lnkData[NSTAGE];
  assign lnkReady[NSTAGE] = outReady;
endmodule

// File: rtl/strm_reg_slice_chk.sv
module strm_reg_slice_chk #(
  parameter int WIDTH = 8,
  parameter int MODE  = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             dropEn,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [WIDTH-1:0] outData
);
  // R3: a stalled output word stays put
  p_hold_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R8: a dropped word is always consumed
  p_drop_accept_r8: assert property (@(posedge clk) disable iff (rst)
    dropEn |-> inReady);

  if (MODE != 1) begin : g_regd
    // R1: registered output is empty after a reset edge
    p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> !outValid);
  end

  if (MODE == 1) begin : g_bwd
    // R5: after a stalled capture the upstream is held off
    p_skid_block_r5: assert property (@(posedge clk) disable iff (rst)
      (outValid && !outReady) |=> (!inReady || dropEn));
  end

  if (MODE == 2) begin : g_half
    // R6: a bubble follows every half-mode output transfer
    p_half_gap_r6: assert property (@(posedge clk) disable iff (rst)
      (outValid && outReady) |=> !outValid);
  end
endmodule

bind strm_reg_slice strm_reg_slice_chk #(.WIDTH(WIDTH), .MODE(MODE)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .dropEn   (dropEn),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData)
);

// File: tb/strm_reg_slice_tb_top.sv
module strm_reg_slice_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst, dropEn, inValid, outReady;
  logic [W-1:0] inData;
  logic         inReadyV  [4];
  logic         outValidV [4];
  logic [W-1:0] outDataV  [4];

  for (genvar m = 0; m < 4; m++) begin : g_mode
    strm_reg_slice #(.WIDTH(W), .MODE(m)) dut_i (
      .clk      (clk),
      .rst      (rst),
      .dropEn   (dropEn),
      .inValid  (inValid),
      .inReady  (inReadyV[m]),
      .inData   (inData),
      .outValid (outValidV[m]),
      .outReady (outReady),
      .outData  (outDataV[m])
    );
  end

  int nCmp = 0;
  int nBad = 0;
  logic [W-1:0] expQ [4][$];
  int outCnt [4];
  bit prevStall [4];
  logic [W-1:0] prevData [4];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit expectTransfer(input bit v, input bit r);
    return v && r;
  endfunction

  // scoreboard, sampled just before the rising edge
  task automatic score();
    for (int m = 0; m < 4; m++) begin
      if (prevStall[m])
        check(outValidV[m] && outDataV[m] == prevData[m], "R3 hold",
              int'(outDataV[m]), int'(prevData[m]));
      if (expectTransfer(inValid, inReadyV[m]) && !dropEn && !rst)
        expQ[m].push_back(inData);
      if (expectTransfer(outValidV[m], outReady) && !rst) begin
        outCnt[m]++;
        if (expQ[m].size() == 0) check(1'b0, "R2 spurious word", int'(outDataV[m]), -1);
        else begin
          logic [W-1:0] e;
          e = expQ[m].pop_front();
          check(outDataV[m] == e, "R2 order", int'(outDataV[m]), int'(e));
        end
      end
      prevStall[m] = outValidV[m] && !outReady && !rst;
      prevData[m]  = outDataV[m];
    end
  endtask

  task automatic finishCycle();
    score();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick();
    #3;
    finishCycle();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      inValid = 1'b0; dropEn = 1'b0; outReady = 1'b1;
      tick();
    end
  endtask

  task automatic clearCnt();
    for (int m = 0; m < 4; m++) outCnt[m] = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'd20240611);
    for (int m = 0; m < 4; m++) begin prevStall[m] = 1'b0; prevData[m] = '0; end
    clearCnt();
    rst = 1'b1; dropEn = 1'b0; inValid = 1'b0; outReady = 1'b0; inData = '0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      #3;
      for (int m = 0; m < 4; m++)
        check(!outValidV[m], "R1 reset valid", int'(outValidV[m]), 0);
      finishCycle();
    end
    rst = 1'b0;

    // continuous flow from empty
    clearCnt();
    for (int i = 0; i < 40; i++) begin
      inValid = 1'b1; dropEn = 1'b0; outReady = 1'b1; inData = W'($urandom);
      #3;
      if (i == 0) begin
        check(outValidV[1] && outDataV[1] == inData, "R5 zero latency",
              int'(outDataV[1]), int'(inData));
        check(!outValidV[0], "R4 latency", int'(outValidV[0]), 0);
        check(!outValidV[3], "R7 latency", int'(outValidV[3]), 0);
      end
      if (i == 1) check(!inReadyV[2], "R6 ready low while full", int'(inReadyV[2]), 0);
      finishCycle();
    end
    check(outCnt[0] == 39, "R4 throughput", outCnt[0], 39);
    check(outCnt[1] == 40, "R5 throughput", outCnt[1], 40);
    check(outCnt[2] == 20, "R6 throughput", outCnt[2], 20);
    check(outCnt[3] == 39, "R7 throughput", outCnt[3], 39);
    idle(6);

    // stall with an empty skid register
    inValid = 1'b1; outReady = 1'b0; inData = 8'hA5;
    #3;
    check(inReadyV[1], "R5 empty skid accepts", int'(inReadyV[1]), 1);
    finishCycle();
    inData = 8'h3C;
    #3;
    check(!inReadyV[1], "R5 skid full blocks", int'(inReadyV[1]), 0);
    check(outValidV[1] && outDataV[1] == 8'hA5, "R5 skid word first",
          int'(outDataV[1]), 8'hA5);
    finishCycle();
    tick();
    idle(6);

    // drop window
    clearCnt();
    for (int i = 0; i < 6; i++) begin
      inValid = 1'b1; dropEn = 1'b1; outReady = 1'b1; inData = W'($urandom);
      #3;
      for (int m = 0; m < 4; m++)
        check(inReadyV[m], "R8 drop consumes", int'(inReadyV[m]), 1);
      finishCycle();
    end
    idle(4);
    for (int m = 0; m < 4; m++)
      check(outCnt[m] == 0, "R8 nothing forwarded", outCnt[m], 0);

    // random traffic in phases of varying back-pressure
    for (int ph = 0; ph < 3; ph++) begin
      for (int i = 0; i < 1500; i++) begin
        inValid  = ($urandom % 4) != 0;
        dropEn   = ($urandom % 6) == 0;
        outReady = (ph == 0) ? (($urandom % 3) != 0) :
                   (ph == 1) ? (($urandom % 2) != 0) : (($urandom % 5) == 0);
        inData   = W'($urandom);
        tick();
      end
    end
    idle(12);
    for (int m = 0; m < 4; m++) begin
      check(expQ[m].size() == 0, "R2 all words delivered", expQ[m].size(), 0);
      check(!outValidV[m], "R2 no extra word", int'(outValidV[m]), 0);
    end

    summary();
    $finish;
  end
endmodule